// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block decides when a four-bank double-data-rate SDRAM must receive an auto-refresh command. It also manages entry into and exit from self-refresh. A free-running interval counter adds one owed refresh each refresh period. Refreshes that are owed are offered to the command arbiter as a request, which stays up until the arbiter grants it. The arbiter is responsible for precharging the banks. It reports this through a flag that says all banks are idle. The scheduler takes a grant only while that flag is high.

Owed refreshes may pile up to a limit, eight by default. At the limit the block raises an urgent flag, and the arbiter must then drain the backlog as a burst. After each granted refresh a recovery window blocks the next request for the refresh row cycle time. During self-refresh the interval phase is frozen and the debt is cleared. On exit, the block reports separately when a bank activate and when a read may be issued again, because the two have different exit delays.

With a 133 MHz command clock the defaults are a 1040-cycle period, 10 recovery cycles, 10 cycles before an activate and 200 cycles before a read.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, ref_req, ref_urgent, recovering and in_selfref are 0, owed_cnt is 0, and act_ready and rd_ready are 1.
- R2: Outside self-refresh, owed_cnt increases by one at every INTERVAL-th rising edge, counted from reset release. The count does not include the edges spent in self-refresh.
- R3: owed_cnt never exceeds MAX_OWED. ref_urgent is 1 exactly while owed_cnt equals MAX_OWED. A period that ends while the count is saturated adds nothing.
- R4: ref_req is 1 whenever owed_cnt is nonzero, the block is not in self-refresh and recovering is 0. Once raised, it stays high until a grant is taken.
- R5: A grant is taken only on an edge where ref_req, ref_grant and bank_idle are all 1. Each taken grant lowers owed_cnt by one. A grant with bank_idle at 0 leaves owed_cnt unchanged.
- R6: After a taken grant, recovering is 1 and ref_req is 0 for the next TRFC cycles. With the grant held, successive refreshes are therefore taken every TRFC+1 cycles.
- R7: sr_enter takes effect only when the block is not in self-refresh, bank_idle is 1, recovering is 0 and no grant is taken on the same edge. When it takes effect, in_selfref becomes 1 and owed_cnt becomes 0.
- R8: While in_selfref is 1, ref_req, act_ready and rd_ready are 0, owed_cnt stays 0 and the interval phase holds. sr_exit then clears in_selfref on the next edge.
- R9: After the edge that leaves self-refresh, act_ready returns to 1 after XSA cycles and rd_ready after XSR cycles.
- R10: When a refresh period ends on the same edge as a taken grant, owed_cnt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_idle | input | 1 | All four banks are precharged |
| ref_grant | input | 1 | Arbiter grants the refresh request |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | An auto-refresh is wanted |
| ref_urgent | output | 1 | Backlog at its limit; the request must not be deferred |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| recovering | output | 1 | Refresh row cycle window still running |
| in_selfref | output | 1 | Memory is in self-refresh |
| act_ready | output | 1 | A bank activate may be issued |
| rd_ready | output | 1 | A read may be issued |

## Verification
The bench builds the block with INTERVAL=16, TRFC=3, XSA=4, XSR=9 and MAX_OWED=8. With these values, saturation is reached in 128 cycles, so every owed level from zero to the limit and past it can be swept one period at a time. The short recovery and exit windows let the bench walk a full eight-deep drain cycle by cycle, with expected values computed arithmetically. The drain is aligned so that a period boundary lands on a taken grant. The self-refresh test places entry at a known interval phase, which shows the frozen phase by the exact edge of the next increment after exit.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 1040,
  parameter int TRFC     = 10,
  parameter int XSA      = 10,
  parameter int XSR      = 200,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bank_idle,
  input  logic ref_grant,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic ref_req,
  output logic ref_urgent,
  output logic [$clog2(MAX_OWED+1)-1:0] owed_cnt,
  output logic recovering,
  output logic in_selfref,
  output logic act_ready,
  output logic rd_ready
);
  localparam int OW   = $clog2(MAX_OWED + 1);
  localparam int IW   = $clog2(INTERVAL);
  localparam int RW   = $clog2(TRFC + 1);
  localparam int XMAX = (XSA > XSR) ? XSA : XSR;
  localparam int XW   = $clog2(XMAX + 1);

  logic [IW-1:0] phase;
  logic [RW-1:0] rfc_left;
  logic [XW-1:0] act_left, rd_left;
  logic tick, take, sr_go, sr_done;

  assign tick       = !in_selfref && (phase == IW'(INTERVAL - 1));
  assign recovering = (rfc_left != '0);
  assign ref_req    = (owed_cnt != '0) && !in_selfref && !recovering;
  assign ref_urgent = (owed_cnt == OW'(MAX_OWED));
  assign take       = ref_req && ref_grant && bank_idle;
  assign sr_go      = sr_enter && !in_selfref && bank_idle && !recovering && !take;
  assign sr_done    = sr_exit && in_selfref;
  assign act_ready  = !in_selfref && (act_left == '0);
  assign rd_ready   = !in_selfref && (rd_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= '0;
      owed_cnt   <= '0;
      rfc_left   <= '0;
      in_selfref <= 1'b0;
      act_left   <= '0;
      rd_left    <= '0;
    end else begin
      if (tick)             phase <= '0;
      else if (!in_selfref) phase <= phase + 1'b1;

      if (in_selfref || sr_go)                 owed_cnt <= '0;
      else if (tick && !take && !ref_urgent)   owed_cnt <= owed_cnt + 1'b1;
      else if (!tick && take)                  owed_cnt <= owed_cnt - 1'b1;

      if (take)                  rfc_left <= RW'(TRFC);
      else if (rfc_left != '0)   rfc_left <= rfc_left - 1'b1;

      if (sr_go)        in_selfref <= 1'b1;
      else if (sr_done) in_selfref <= 1'b0;

      if (sr_done)               act_left <= XW'(XSA);
      else if (act_left != '0)   act_left <= act_left - 1'b1;

      if (sr_done)               rd_left <= XW'(XSR);
      else if (rd_left != '0)    rd_left <= rd_left - 1'b1;
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int MAX_OWED = 8
) (
  input logic clk,
  input logic rst_n,
  input logic bank_idle,
  input logic ref_grant,
  input logic sr_enter,
  input logic ref_req,
  input logic [$clog2(MAX_OWED+1)-1:0] owed_cnt,
  input logic recovering,
  input logic in_selfref,
  input logic act_ready,
  input logic rd_ready
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= ($clog2(MAX_OWED+1))'(MAX_OWED));

  p_saturate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_cnt == ($clog2(MAX_OWED+1))'(MAX_OWED) && !ref_grant && !sr_enter)
      |=> owed_cnt == ($clog2(MAX_OWED+1))'(MAX_OWED));

  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant && !sr_enter) |=> ref_req);

  p_grant_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ref_grant || !bank_idle) && !sr_enter) |=> owed_cnt >= $past(owed_cnt));

  p_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant && bank_idle) |=> (recovering && !ref_req));

  p_sr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_selfref |-> (!ref_req && !act_ready && !rd_ready && owed_cnt == '0));

  p_exit_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_selfref) |-> (!act_ready && !rd_ready));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.MAX_OWED(MAX_OWED)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .ref_grant(ref_grant),
  .sr_enter(sr_enter), .ref_req(ref_req), .owed_cnt(owed_cnt),
  .recovering(recovering), .in_selfref(in_selfref),
  .act_ready(act_ready), .rd_ready(rd_ready)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int IV = 16, RF = 3, XA = 4, XR = 9, MX = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bank_idle = 1'b0, ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ref_req, ref_urgent, recovering, in_selfref, act_ready, rd_ready;
  logic [3:0] owed_cnt;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_sched #(.INTERVAL(IV), .TRFC(RF), .XSA(XA), .XSR(XR), .MAX_OWED(MX)) u0 (
    .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .ref_grant(ref_grant),
    .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .owed_cnt(owed_cnt), .recovering(recovering), .in_selfref(in_selfref),
    .act_ready(act_ready), .rd_ready(rd_ready));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    bank_idle = 0; ref_grant = 0; sr_enter = 0; sr_exit = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 req", ref_req, 0);
    chk("R1 urgent", ref_urgent, 0);
    chk("R1 owed", owed_cnt, 0);
    chk("R1 recovering", recovering, 0);
    chk("R1 in_selfref", in_selfref, 0);
    chk("R1 act_ready", act_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);

    // R2/R3 sweep of periods, with saturation at MX
    for (int i = 1; i <= 10; i++) begin
      step(IV - 1);
      chk("R2 before period end", owed_cnt, (i - 1 > MX) ? MX : i - 1);
      step(1);
      chk("R2 period end", owed_cnt, (i > MX) ? MX : i);
      chk("R3 urgent", ref_urgent, (i >= MX) ? 1 : 0);
      chk("R4 req held", ref_req, 1);
    end

    // R5: grant without bank_idle is ignored
    ref_grant = 1;
    step(3);
    chk("R5 no idle owed", owed_cnt, MX);
    chk("R5 no idle req", ref_req, 1);

    // R5/R6/R10 drain with grant held; period ends on edge 13
    bank_idle = 1;
    for (int r = 1; r <= 17; r++) begin
      int exp_owed;
      int busy;
      step(1);
      exp_owed = MX - (r + 3) / 4 + ((r >= 13) ? 1 : 0);
      busy = ((r - 1) % 4 != 3) ? 1 : 0;
      chk((r == 13) ? "R10 tick with grant" : "R5 drain owed", owed_cnt, exp_owed);
      chk("R6 recovering", recovering, busy);
      chk("R6 req gap", ref_req, busy ? 0 : 1);
    end

    // R7: entry refused while recovering
    ref_grant = 0; sr_enter = 1;
    step(1);
    sr_enter = 0;
    chk("R7 busy entry refused", in_selfref, 0);
    chk("R7 busy owed kept", owed_cnt, 4);

    // Self-refresh sequence
    do_reset();
    step(2 * IV + 5);
    chk("R4 req without grant", ref_req, 1);
    chk("R2 two periods", owed_cnt, 2);
    sr_enter = 1;
    step(1);
    chk("R7 entry refused not idle", in_selfref, 0);
    chk("R7 owed kept", owed_cnt, 2);
    bank_idle = 1;
    step(1);
    sr_enter = 0;
    chk("R7 entered", in_selfref, 1);
    chk("R7 owed cleared", owed_cnt, 0);
    chk("R8 req low", ref_req, 0);
    chk("R8 act low", act_ready, 0);
    chk("R8 rd low", rd_ready, 0);
    step(50);
    chk("R8 still in", in_selfref, 1);
    chk("R8 owed stays 0", owed_cnt, 0);
    sr_exit = 1;
    step(1);
    sr_exit = 0;
    chk("R8 exit", in_selfref, 0);
    // phase held at 7 during self-refresh: next increment 9 edges after exit
    for (int j = 0; j <= 12; j++) begin
      if (j > 0) step(1);
      chk("R9 act_ready", act_ready, (j >= XA) ? 1 : 0);
      chk("R9 rd_ready", rd_ready, (j >= XR) ? 1 : 0);
      chk("R8 phase frozen", owed_cnt, (j >= 9) ? 1 : 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule